// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects eight device interrupt request lines and presents one interrupt line to a processor. Requests are first captured in a pending register. A fixed-priority resolver then picks the best unmasked pending line and compares it against the lines whose handlers are already running. The interrupt output is raised only when the candidate outranks every running handler. When the processor acknowledges, the block hands back a vector equal to a programmable base plus the winning line number. It marks that line as in service and drops its pending bit. An end-of-interrupt pulse retires the most urgent in-service line, so handlers can nest strictly by priority.

A small three-state machine drives the processor side. `S_IDLE` waits for a request that may interrupt. The transition `GO_RAISE` leads to `S_RAISE`, where the interrupt output is high. From `S_RAISE`, the transition `TAKE_ACK` moves to `S_DELIVER` when the acknowledge arrives while the candidate is still valid. The transition `WITHDRAW` returns to `S_IDLE` if the candidate vanishes, for example because it was masked. `S_DELIVER` presents the vector with its valid flag for exactly one cycle, then always takes `DONE` back to `S_IDLE`. Software programs the vector base and the per-line mask through a one-word write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_out` and `vec_valid` are 0, no line is pending or in service, the mask is all zeros and the vector base is 0x20.
- R2: A request that is high at one rising edge sets that line's pending bit, which then stays set until that line is acknowledged, even if the request input falls.
- R3: Among unmasked pending lines, the lowest line number wins (line 0 highest, line 7 lowest).
- R4: `irq_out` rises at the second rising edge after a qualifying request is sampled. It is high only while the best unmasked pending line has a lower number than every in-service line, or no line is in service.
- R5: `ack_in` high at an edge where `irq_out` is high gives `vec_valid` high for exactly the next cycle. During that cycle `vec_out` equals (base + winning line number) modulo 256.
- R6: `ack_in` while `irq_out` is low is ignored: no vector is delivered and no pending or in-service state changes.
- R7: While a line is in service, requests on that line or on any higher-numbered line do not raise `irq_out`.
- R8: A request on a lower-numbered line than every in-service line raises `irq_out` and nests on top of the running handler.
- R9: An `eoi_in` pulse clears only the lowest-numbered in-service bit. Any waiting request it had blocked then raises `irq_out` one cycle after the clearing edge.
- R10: A masked line keeps its pending bit but never wins. Clearing its mask bit lets it raise `irq_out`.
- R11: With `cfg_we` high, `cfg_sel` = 0 writes `cfg_wdata` into the vector base. `cfg_sel` = 1 writes it into the mask, where bit i set masks line i.
- R12: Acknowledge clears the winner's pending bit. A request line still held high re-latches on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Device request lines, bit i is line i |
| irq_out | output | 1 | Interrupt line to the processor |
| ack_in | input | 1 | Processor acknowledge |
| vec_out | output | 8 | Vector of the acknowledged line |
| vec_valid | output | 1 | High for one cycle when `vec_out` is valid |
| eoi_in | input | 1 | End-of-interrupt pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects vector base, 1 selects mask |
| cfg_wdata | input | 8 | Configuration write data |

## Verification
The embedded properties check, on every cycle, the following:
- A delivered vector always follows an acknowledge taken while the interrupt was raised, and it lasts only one cycle.
- The interrupt output never stands without a qualifying candidate in the cycle before.
- Pending bits are never lost without an acknowledge.
- The in-service set grows by at most one line per cycle, and an end-of-interrupt removes exactly one line.

Only the directed scenarios can show the rest:
- the actual ordering of winners;
- the vector arithmetic, including wraparound;
- blocking by equal or lower in-service lines and nesting above them;
- masking and unmasking;
- stray acknowledges;
- re-latching of a held request.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_LINES = 8;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int VEC_W     = 8;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_RAISE   = 2'd1,
        S_DELIVER = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req,
    input  logic [LINES-1:0] clr,
    output logic [LINES-1:0] pend
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend[g] <= 1'b0;
                else if (clr[g])
                    pend[g] <= 1'b0;
                else if (req[g])
                    pend[g] <= 1'b1;
            end
        end
    endgenerate

    // R2: a pending bit only drops when its line is acknowledged
    p_pend_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend & ~clr) & ~pend) == '0));
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
    parameter int LINES = 8,
    parameter int IW    = $clog2(LINES)
) (
    input  logic [LINES-1:0] pend,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] isr,
    output logic             want,
    output logic [IW-1:0]    win_idx
);
    logic [LINES-1:0] elig;
    logic             any_elig;
    logic             any_isr;
    logic [IW-1:0]    isr_idx;

    assign elig = pend & ~mask;

    always_comb begin
        win_idx  = '0;
        any_elig = 1'b0;
        isr_idx  = '0;
        any_isr  = 1'b0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_idx  = IW'(i);
                any_elig = 1'b1;
            end
            if (isr[i]) begin
                isr_idx = IW'(i);
                any_isr = 1'b1;
            end
        end
        want = any_elig && (!any_isr || (win_idx < isr_idx));
    end

    // R3: the winner is always an eligible line
    always_comb begin
        if (want) begin
            a_win_eligible_r3: assert (elig[win_idx]);
        end
    end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set_vec,
    input  logic             eoi,
    output logic [LINES-1:0] isr
);
    logic [LINES-1:0] retire;

    always_comb begin
        retire = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (isr[i]) retire = LINES'(1) << i;
        end
        if (!eoi) retire = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            isr <= '0;
        else
            isr <= (isr | set_vec) & ~retire;
    end

    // R7: the in-service set grows by at most one line per cycle
    p_isr_grow_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(isr) <= $countones($past(isr)) + 1));

    // R9: an end-of-interrupt with nothing being set removes exactly one line
    p_eoi_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (isr != '0) && (set_vec == '0)) |=>
            ($countones(isr) + 1 == $countones($past(isr))));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter logic [VEC_W-1:0] BASE_RST = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 irq_out,
    input  logic                 ack_in,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 vec_valid,
    input  logic                 eoi_in,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [VEC_W-1:0]     cfg_wdata
);
    ctrl_state_t          state, state_nx;
    logic [NUM_LINES-1:0] pend, isr, mask_q, clr_vec;
    logic [VEC_W-1:0]     base_q;
    logic                 want, take;
    logic [IDX_W-1:0]     win_idx;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= BASE_RST;
            mask_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) mask_q <= cfg_wdata[NUM_LINES-1:0];
            else         base_q <= cfg_wdata;
        end
    end

    irq_req_latch #(.LINES(NUM_LINES)) u_latch (
        .clk(clk), .rst_n(rst_n), .req(irq_in), .clr(clr_vec), .pend(pend)
    );

    irq_prio_resolve #(.LINES(NUM_LINES), .IW(IDX_W)) u_resolve (
        .pend(pend), .mask(mask_q), .isr(isr), .want(want), .win_idx(win_idx)
    );

    irq_inservice #(.LINES(NUM_LINES)) u_isr (
        .clk(clk), .rst_n(rst_n), .set_vec(clr_vec), .eoi(eoi_in), .isr(isr)
    );

    assign take    = (state == S_RAISE) && want && ack_in;
    assign clr_vec = take ? (NUM_LINES'(1) << win_idx) : '0;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (want) state_nx = S_RAISE;           // GO_RAISE
            S_RAISE: begin
                if (!want)       state_nx = S_IDLE;            // WITHDRAW
                else if (ack_in) state_nx = S_DELIVER;         // TAKE_ACK
            end
            S_DELIVER:           state_nx = S_IDLE;            // DONE
            default:             state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // vector capture
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_out <= '0;
        else if (take)
            vec_out <= base_q + {{(VEC_W-IDX_W){1'b0}}, win_idx};
    end

    // outputs
    always_comb begin
        irq_out   = 1'b0;
        vec_valid = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_RAISE:   irq_out   = 1'b1;
            S_DELIVER: vec_valid = 1'b1;
            default:   ;
        endcase
    end

    // R5: a vector is only delivered after an acknowledge of a raised interrupt
    p_vec_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(irq_out && ack_in));

    // R5: the valid flag lasts one cycle
    p_vec_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R4: the interrupt line stands only on a qualifying candidate
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(want));

    // R6: an acknowledge outside the raised state touches no in-service bit
    p_stray_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && !eoi_in) |=> ((isr & ~$past(isr)) == '0));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_in;
    logic       irq_out;
    logic       ack_in;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic       eoi_in;
    logic       cfg_we;
    logic       cfg_sel;
    logic [7:0] cfg_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
        .ack_in(ack_in), .vec_out(vec_out), .vec_valid(vec_valid),
        .eoi_in(eoi_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_lines(input logic [7:0] m);
        irq_in = m;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic do_ack(input string req, input logic [7:0] exp_vec);
        chk({req, " irq before ack"}, 32'(irq_out), 32'd1);
        ack_in = 1'b1;
        @(negedge clk);
        ack_in = 1'b0;
        chk({req, " vec_valid"}, 32'(vec_valid), 32'd1);
        chk({req, " vec_out"}, 32'(vec_out), 32'(exp_vec));
        @(negedge clk);
        chk({req, " valid one cycle"}, 32'(vec_valid), 32'd0);
    endtask

    task automatic do_eoi();
        eoi_in = 1'b1;
        @(negedge clk);
        eoi_in = 1'b0;
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq_out at reset", 32'(irq_out), 32'd0);
        chk("R1 vec_valid at reset", 32'(vec_valid), 32'd0);
    endtask

    task automatic t_single();
        pulse_lines(8'h08);
        chk("R4 irq not yet", 32'(irq_out), 32'd0);
        wait_n(1);
        chk("R2 R4 irq after pulse", 32'(irq_out), 32'd1);
        do_ack("R5 line3", 8'h23);
        do_eoi();
        wait_n(2);
        chk("R9 idle after eoi", 32'(irq_out), 32'd0);
    endtask

    task automatic t_priority();
        pulse_lines(8'h24);
        wait_n(1);
        do_ack("R3 line2 wins", 8'h22);
        wait_n(1);
        chk("R7 line5 blocked by line2", 32'(irq_out), 32'd0);
        do_eoi();
        wait_n(1);
        chk("R9 line5 released", 32'(irq_out), 32'd1);
        do_ack("R3 line5 second", 8'h25);
        do_eoi();
        wait_n(2);
        chk("R12 line2 pending cleared", 32'(irq_out), 32'd0);
    endtask

    task automatic t_nest();
        pulse_lines(8'h40);
        wait_n(1);
        do_ack("R8 line6 outer", 8'h26);
        pulse_lines(8'h02);
        wait_n(1);
        chk("R8 line1 nests", 32'(irq_out), 32'd1);
        do_ack("R8 line1 inner", 8'h21);
        pulse_lines(8'h10);
        wait_n(2);
        chk("R7 line4 waits", 32'(irq_out), 32'd0);
        do_eoi();
        wait_n(1);
        chk("R9 eoi retires line1 only", 32'(irq_out), 32'd1);
        do_ack("R8 line4 above line6", 8'h24);
        do_eoi();
        pulse_lines(8'h40);
        wait_n(2);
        chk("R7 equal line6 waits", 32'(irq_out), 32'd0);
        do_eoi();
        wait_n(1);
        chk("R9 line6 again", 32'(irq_out), 32'd1);
        do_ack("R7 line6 repeat", 8'h26);
        do_eoi();
        wait_n(2);
        chk("R9 all retired", 32'(irq_out), 32'd0);
    endtask

    task automatic t_mask();
        cfg_write(1'b1, 8'h01);
        pulse_lines(8'h01);
        wait_n(3);
        chk("R10 masked line0 silent", 32'(irq_out), 32'd0);
        cfg_write(1'b1, 8'h00);
        wait_n(1);
        chk("R10 R11 unmask releases", 32'(irq_out), 32'd1);
        do_ack("R10 line0", 8'h20);
        do_eoi();
    endtask

    task automatic t_base();
        cfg_write(1'b0, 8'hFC);
        pulse_lines(8'h80);
        wait_n(1);
        do_ack("R11 R5 base wrap", 8'h03);
        do_eoi();
        cfg_write(1'b0, 8'h20);
    endtask

    task automatic t_stray_ack();
        wait_n(2);
        ack_in = 1'b1;
        @(negedge clk);
        ack_in = 1'b0;
        chk("R6 no vector on stray ack", 32'(vec_valid), 32'd0);
        wait_n(1);
        chk("R6 irq still low", 32'(irq_out), 32'd0);
        pulse_lines(8'h20);
        wait_n(1);
        chk("R6 state untouched", 32'(irq_out), 32'd1);
        do_ack("R6 line5 after stray", 8'h25);
        do_eoi();
    endtask

    task automatic t_relatch();
        irq_in = 8'h08;
        wait_n(2);
        do_ack("R12 held line3", 8'h23);
        do_eoi();
        wait_n(1);
        chk("R12 relatched", 32'(irq_out), 32'd1);
        irq_in = '0;
        do_ack("R12 line3 again", 8'h23);
        do_eoi();
        wait_n(2);
        chk("R12 gone after drop", 32'(irq_out), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; ack_in = 1'b0; eoi_in = 1'b0;
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_single();
        t_priority();
        t_nest();
        t_mask();
        t_base();
        t_stray_ack();
        t_relatch();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule